// File: doc/BRIEF.md
# Cascadable Synchronous Line Buffer

This block is a single-clock byte memory with one write data port and one read data port and no address pins. Two internal 16-bit address counters, one per port, choose the array location. Each counter steps up or down on every clock edge where its port enable is high. A reload strobe either copies the counter's 16-bit reload value into it or clears it. The low bits of a counter index the array. The top three bits are compared with a programmable expand ID, so several buffers can share one long address space: only the device whose ID matches takes part in a transfer.

A read and a write may hit the same location on the same edge. The read returns the byte stored before that edge, and the new byte is then stored. Because of this, the data output of one buffer can drive the data input of the next to form a delay line. Read data is registered. A separate drive-enable output tells the pad logic when the read port should drive the bus. That enable comes from the active-low output-enable input, used either directly or sampled on the clock edge.

An 8-bit configuration word holds the expand ID (bits 2:0), the write reload mode (bit 3), the write direction (bit 4), the read reload mode (bit 5), the read direction (bit 6) and the output-enable mode (bit 7). The block captures this word on every clock edge.

Top module: `line_buf`

## Requirements
- R1: When the write enable is high and the write counter's bits 15:13 equal configuration bits 2:0, the clock edge stores the input byte at the array index given by the write counter's low bits. When the read enable is high and the read counter's top bits match, the stored byte at the read index appears on the data output after that edge.
- R2: A read and a write to the same index on the same edge return the byte stored before the edge on the data output, and a later read of that index returns the new byte.
- R3: A counter whose enable is high and whose reload is low moves by one on the edge: up when its direction bit is 0, down when it is 1. The write direction is configuration bit 4 and the read direction is bit 6. With enable and reload both low, the counter holds.
- R4: An up-counting counter goes from 16'hFFFF to 16'h0000, and a down-counting counter goes from 16'h0000 to 16'hFFFF.
- R5: A reload strobe sets the counter to its 16-bit reload value when the port's reload-mode bit is 1. The write reload-mode bit is configuration bit 3 and the read reload-mode bit is bit 5. When the reload-mode bit is 0, the strobe clears the counter to 16'h0000 if the port counts up and to 16'hFFFF if it counts down.
- R6: When a reload and an enable arrive on the same edge, the counter takes the reload result and skips the step. The access on that edge still uses the counter value from before the reload.
- R7: When the counter's top bits do not match the expand ID, a write is suppressed. An enabled read leaves the data output unchanged and drops the drive-enable output until a later enabled read matches. The counter still steps in both cases.
- R8: When configuration bit 7 is 0, the drive enable follows the inverted output-enable pin at once. When bit 7 is 1, the drive enable follows the pin's value sampled on the last clock edge. In both modes the drive enable is low while the read port is inactive.
- R9: Reset clears the captured configuration word, both counters and the data output, and marks the read port active. The configuration input takes effect from the clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 8 | Configuration word, captured every edge |
| wr_en | input | 1 | Write the input byte and step the write counter |
| wr_reload | input | 1 | Reload or clear the write counter |
| wr_reload_val | input | 16 | Value loaded into the write counter on reload |
| din | input | 8 | Write data |
| rd_en | input | 1 | Read a byte and step the read counter |
| rd_reload | input | 1 | Reload or clear the read counter |
| rd_reload_val | input | 16 | Value loaded into the read counter on reload |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 8 | Registered read data |
| dout_oe | output | 1 | High when the read port should drive the data bus |

## Verification
Assertions check on every cycle that each counter steps, holds or reloads as the enables, reload strobes and configuration bits dictate. They also check that the data output only moves after an enabled read, and that the drive enable obeys the asynchronous or sampled output-enable mode. Stored contents cannot be seen from a single cycle, so only the bench scenarios show them. These scenarios cover old-data-first behaviour on a shared address, writes dropped under an ID mismatch, and counter wrap at both ends. They also confirm that a counter keeps moving while its port is inactive, by reading back at addresses reached only through that movement.

// File: rtl/line_buf.sv
module line_buf #(
  parameter int DW    = 8,
  parameter int IDX_W = 13,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg,
  input  logic          wr_en,
  input  logic          wr_reload,
  input  logic [CW-1:0] wr_reload_val,
  input  logic [DW-1:0] din,
  input  logic          rd_en,
  input  logic          rd_reload,
  input  logic [CW-1:0] rd_reload_val,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  localparam int IDW   = 3;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [7:0]    cfg_q;
  logic [CW-1:0] wr_cnt, rd_cnt;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic          hit_q, oe_q;

  wire [IDW-1:0] id       = cfg_q[IDW-1:0];
  wire           wr_load  = cfg_q[3];
  wire           wr_down  = cfg_q[4];
  wire           rd_load  = cfg_q[5];
  wire           rd_down  = cfg_q[6];
  wire           oe_sync  = cfg_q[7];
  wire           wr_match = wr_cnt[CW-1 -: IDW] == id;
  wire           rd_match = rd_cnt[CW-1 -: IDW] == id;

  function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] c, input logic en,
                                             input logic rl, input logic load,
                                             input logic down, input logic [CW-1:0] val);
    if (rl)      return load ? val : {CW{down}};
    else if (en) return down ? c - ONE : c + ONE;
    else         return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      wr_cnt <= '0;
      rd_cnt <= '0;
    end else begin
      cfg_q  <= cfg;
      wr_cnt <= next_cnt(wr_cnt, wr_en, wr_reload, wr_load, wr_down, wr_reload_val);
      rd_cnt <= next_cnt(rd_cnt, rd_en, rd_reload, rd_load, rd_down, rd_reload_val);
    end
  end

  always_ff @(posedge clk)
    if (rst_n && wr_en && wr_match) mem[wr_cnt[IDX_W-1:0]] <= din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      hit_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= ~oe_n;
      if (rd_en) begin
        hit_q <= rd_match;
        if (rd_match) rd_q <= mem[rd_cnt[IDX_W-1:0]];
      end
    end
  end

  assign dout    = rd_q;
  assign dout_oe = hit_q & (oe_sync ? oe_q : ~oe_n);
endmodule

module line_buf_chk #(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_reload,
  input logic          rd_en,
  input logic          rd_reload,
  input logic          oe_n,
  input logic [CW-1:0] wr_reload_val,
  input logic [CW-1:0] rd_reload_val,
  input logic [7:0]    cfg_q,
  input logic [CW-1:0] wr_cnt,
  input logic [CW-1:0] rd_cnt,
  input logic          hit_q,
  input logic [DW-1:0] dout,
  input logic          dout_oe
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  // R3
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_en) && !$past(wr_reload) |->
      wr_cnt == ($past(cfg_q[4]) ? $past(wr_cnt) - ONE : $past(wr_cnt) + ONE));

  // R3
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(rd_en) && !$past(rd_reload) |->
      rd_cnt == ($past(cfg_q[6]) ? $past(rd_cnt) - ONE : $past(rd_cnt) + ONE));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(rd_en) && !$past(rd_reload) && !$past(wr_en) && !$past(wr_reload) |->
      $stable(rd_cnt) && $stable(wr_cnt));

  // R5
  wr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_reload) |->
      wr_cnt == ($past(cfg_q[3]) ? $past(wr_reload_val) : {CW{$past(cfg_q[4])}}));

  // R5
  rd_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(rd_reload) |->
      rd_cnt == ($past(cfg_q[5]) ? $past(rd_reload_val) : {CW{$past(cfg_q[6])}}));

  // R7
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(rd_en) |-> $stable(dout) && $stable(hit_q));

  // R8
  oe_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && cfg_q[7] && dout_oe |-> !$past(oe_n));

  // R8
  oe_async_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[7] && oe_n |-> !dout_oe);
endmodule

bind line_buf line_buf_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reload(wr_reload),
  .rd_en(rd_en), .rd_reload(rd_reload), .oe_n(oe_n),
  .wr_reload_val(wr_reload_val), .rd_reload_val(rd_reload_val),
  .cfg_q(cfg_q), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt), .hit_q(hit_q),
  .dout(dout), .dout_oe(dout_oe));

// File: tb/line_buf_tb.sv
module line_buf_tb;
  localparam int IDX_W = 4;
  localparam int N = 1 << IDX_W;

  logic clk = 0;
  logic rst_n;
  logic [7:0] cfg;
  logic wr_en, wr_reload, rd_en, rd_reload, oe_n;
  logic [15:0] wr_reload_val, rd_reload_val;
  logic [7:0] din, dout;
  logic dout_oe;

  int checks = 0, fails = 0;
  logic [7:0] exp_mem [N];
  logic [7:0] held;

  always #10 clk = ~clk;

  line_buf #(.DW(8), .IDX_W(IDX_W), .CW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .wr_en(wr_en), .wr_reload(wr_reload),
    .wr_reload_val(wr_reload_val), .din(din), .rd_en(rd_en), .rd_reload(rd_reload),
    .rd_reload_val(rd_reload_val), .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic cyc(input logic we, input logic re, input logic wrl, input logic rrl,
                     input logic [7:0] d);
    wr_en = we; rd_en = re; wr_reload = wrl; rd_reload = rrl; din = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; wr_reload = 0; rd_reload = 0;
  endtask

  task automatic setcfg(input logic [7:0] c);
    cfg = c;
    cyc(0, 0, 0, 0, 8'h00);
  endtask

  task automatic rd(input string tag, input logic [7:0] ev, input logic eoe);
    cyc(0, 1, 0, 0, 8'h00);
    chk(tag, {8'h00, dout}, {8'h00, ev});
    chk(tag, {15'h0, dout_oe}, {15'h0, eoe});
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; cfg = 0; wr_en = 0; rd_en = 0; wr_reload = 0; rd_reload = 0;
    oe_n = 1; din = 0; wr_reload_val = 0; rd_reload_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R9 dout after reset", {8'h00, dout}, 16'h0000);
    chk("R9 oe off with pin high", {15'h0, dout_oe}, 16'h0000);
    oe_n = 0; #2;
    chk("R9 R8 async oe, port active after reset", {15'h0, dout_oe}, 16'h0001);

    // R1 R3: fill upward then read back upward
    for (int i = 0; i < N; i++) begin
      exp_mem[i] = 8'((i * 7 + 3) & 8'hFF);
      cyc(1, 0, 0, 0, exp_mem[i]);
    end
    cyc(0, 0, 0, 1, 8'h00);
    for (int i = 0; i < N; i++) rd("R1 up read", exp_mem[i], 1'b1);

    // R5 R3: down count after clear -> FFFF, id 7 matches top bits
    setcfg(8'h47);
    cyc(0, 0, 0, 1, 8'h00);
    for (int k = 0; k < N; k++) rd("R5 R3 down read from FFFF", exp_mem[N-1-k], 1'b1);

    // R7: writes with id 7 while write counter top bits are 000 are dropped
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 8'hEE);
    rd_reload_val = 16'h0000;
    setcfg(8'h20);
    cyc(0, 0, 0, 1, 8'h00);
    for (int i = 0; i < 4; i++) rd("R7 suppressed write", exp_mem[i], 1'b1);
    exp_mem[4] = 8'h5A;
    cyc(1, 0, 0, 0, 8'h5A);
    rd("R7 write counter stepped while inactive", 8'h5A, 1'b1);

    // R7: crossing into another ID region
    rd_reload_val = 16'h1FFE;
    cyc(0, 0, 0, 1, 8'h00);
    rd("R7 at 1FFE", exp_mem[14], 1'b1);
    rd("R7 at 1FFF", exp_mem[15], 1'b1);
    rd("R7 mismatch at 2000 holds dout, drops oe", exp_mem[15], 1'b0);
    setcfg(8'h21);
    chk("R7 oe stays low until a matching read", {15'h0, dout_oe}, 16'h0000);
    rd("R7 read counter stepped while inactive", exp_mem[1], 1'b1);

    // R2: same-address read and write
    wr_reload_val = 16'h0003; rd_reload_val = 16'h0003;
    setcfg(8'h28);
    cyc(0, 0, 1, 1, 8'h00);
    cyc(1, 1, 0, 0, 8'hA5);
    chk("R2 old data returned", {8'h00, dout}, {8'h00, exp_mem[3]});
    exp_mem[3] = 8'hA5;
    cyc(0, 0, 0, 1, 8'h00);
    rd("R2 new data stored", 8'hA5, 1'b1);

    // R6: reload wins over step, access uses old address
    rd_reload_val = 16'h0009;
    cyc(0, 1, 0, 1, 8'h00);
    chk("R6 read at pre-reload address", {8'h00, dout}, {8'h00, exp_mem[4]});
    rd("R6 counter took reload value", exp_mem[9], 1'b1);
    rd("R6 then steps", exp_mem[10], 1'b1);

    // R4: up wrap FFFF -> 0000
    rd_reload_val = 16'hFFFE;
    setcfg(8'h27);
    cyc(0, 0, 0, 1, 8'h00);
    rd("R4 at FFFE", exp_mem[14], 1'b1);
    rd("R4 at FFFF", exp_mem[15], 1'b1);
    rd("R4 wrapped to 0000 outside id 7", exp_mem[15], 1'b0);
    setcfg(8'h20);
    rd("R4 next is 0001", exp_mem[1], 1'b1);

    // R4: down wrap 0000 -> FFFF
    rd_reload_val = 16'h0001;
    setcfg(8'h60);
    cyc(0, 0, 0, 1, 8'h00);
    rd("R4 down at 0001", exp_mem[1], 1'b1);
    rd("R4 down at 0000", exp_mem[0], 1'b1);
    rd("R4 down wrapped to FFFF outside id 0", exp_mem[0], 1'b0);

    // R5 R3: write counter cleared to FFFF when counting down
    setcfg(8'h17);
    cyc(0, 0, 1, 0, 8'h00);
    cyc(1, 0, 0, 0, 8'h11); exp_mem[15] = 8'h11;
    cyc(1, 0, 0, 0, 8'h22); exp_mem[14] = 8'h22;
    rd_reload_val = 16'h000E;
    setcfg(8'h20);
    cyc(0, 0, 0, 1, 8'h00);
    rd("R5 down write at FFFE", 8'h22, 1'b1);
    rd("R5 down write at FFFF", 8'h11, 1'b1);

    // R8: sampled versus immediate output enable
    setcfg(8'hA0);
    chk("R8 sync oe on", {15'h0, dout_oe}, 16'h0001);
    oe_n = 1; #2;
    chk("R8 sync oe waits for edge", {15'h0, dout_oe}, 16'h0001);
    @(negedge clk);
    chk("R8 sync oe after edge", {15'h0, dout_oe}, 16'h0000);
    setcfg(8'h20);
    oe_n = 0; #2;
    chk("R8 async oe immediate on", {15'h0, dout_oe}, 16'h0001);
    oe_n = 1; #2;
    chk("R8 async oe immediate off", {15'h0, dout_oe}, 16'h0000);
    summary();
  end
endmodule